// File: doc/BRIEF.md
# Four-Channel Vectored Counter/Timer

This peripheral holds four down-counting channels, numbered 0 to 3, that share one byte-wide register port. The port selects a channel, and a write to that channel carries either a control word, a time constant or the shared interrupt vector base. A read at any time returns the selected channel's current count.

Each channel works in one of two ways. As a timer, it decrements once every 16 or 256 system clocks. As a counter, it decrements on each chosen edge of its own trigger input. A timer can also be held until a trigger edge starts it. When a count runs out, the channel reloads its time constant by itself and keeps running. Channels 0 to 2 then emit a one-clock zero-count pulse. If interrupts are enabled, the channel also raises an interrupt request.

Pending requests are served in fixed priority, channel 0 first. The vector presented for a request is the programmed base with the channel number inserted into it. An acknowledge strobe clears the request that is currently being presented.

Top module: `quad_timer`

## Requirements
- R1: A write whose bit 0 is 0 is a vector word, unless that channel is waiting for a time constant. A vector word stores bits 7:3 as the shared vector base, which appears as `irq_vec[7:3]`. Any other write leaves the base unchanged.
- R2: A write whose bit 0 is 1 is a control word. Its bits are: 7 interrupt enable, 6 counter mode, 5 divide-by-256 (0 selects 16), 4 rising trigger edge (0 selects falling), 3 timer waits for a trigger edge, 2 time constant follows, 1 stop. When bit 2 is set, the next write to that channel is taken as its time constant whatever its bit 0 holds. That time constant then appears on `rd_data` in the following cycle if the channel was stopped.
- R3: In timer mode the count drops once every 16 or 256 clocks, as bit 5 selects, so the zero-count pulses repeat every time-constant × divider clocks.
- R4: A time constant of 0 gives 256 counts between reloads.
- R5: When the count runs out, the channel reloads the time constant and keeps running without any further write. Channels 0 to 2 each pulse their `zc` bit high for exactly one clock at that moment.
- R6: In counter mode the count drops once per selected edge of the channel's `trig` bit. Edges of the other polarity have no effect.
- R7: With bit 3 set in timer mode, a loaded channel holds its count until the first selected trigger edge, and only then starts to divide.
- R8: A control word with bit 1 set halts the channel. Its count then holds, and it makes no zero-count pulse until a new time constant is loaded.
- R9: A zero count on a channel with interrupts enabled sets that channel's request. `irq` is high while any request is set. `irq_vec` is {base, number of the lowest-numbered requesting channel in bits 2:1, 0}. A channel whose interrupts are disabled never raises `irq`.
- R10: An `irq_ack` pulse while `irq` is high clears only the request presented in `irq_vec`, so the next one in priority is then presented.
- R11: After reset, all channels are stopped with count 0. `irq`, `irq_vec` and `zc` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel | input | 2 | Channel addressed by the register port |
| wr_en | input | 1 | Write strobe, one byte per clock |
| wr_data | input | 8 | Write byte |
| rd_data | output | 8 | Current count of the selected channel |
| trig | input | 4 | Per-channel trigger/count input, synchronous to clk |
| zc | output | 3 | Zero-count pulses of channels 0 to 2 |
| irq | output | 1 | Interrupt request |
| irq_vec | output | 8 | Vector of the highest-priority requesting channel |
| irq_ack | input | 1 | Acknowledge, clears the presented request |

## Verification
The bound checker watches, on every cycle, rules that hold regardless of programming:
- a zero-count pulse never lasts two clocks;
- the vector base never moves without a write;
- the presented channel always has a pending request, and no lower-numbered channel is pending;
- the presented channel number never moves to a lower priority unless an acknowledge came first.

Division ratios, the 256-count case, counter-edge polarity, trigger-started timing, stopping, and the order in which requests are served and cleared depend on the programmed values and the stimulus. Only the bench's scenarios can show these, by measuring pulse periods and reading counts back.

// File: rtl/qt_pkg.sv
package qt_pkg;
  localparam int BUS_W = 8;

  typedef struct packed {
    logic ie;         // interrupt enable
    logic cnt_mode;   // 1: count trigger edges
    logic div_hi;     // 1: divide by 256, 0: by 16
    logic rise;       // 1: rising edge active
    logic trig_start; // timer waits for trigger edge
    logic tc_next;    // next write is time constant
    logic stop;       // halt channel
    logic is_ctl;     // 1 marks a control word
  } ctl_t;
endpackage

// File: rtl/qt_channel.sv
module qt_channel
  import qt_pkg::*;
#(
  parameter int PRE_LO_LOG2 = 4,
  parameter int PRE_HI_LOG2 = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [BUS_W-1:0] wdata,
  input  logic             trig,
  input  logic             clr_pend,
  output logic [BUS_W-1:0] cnt,
  output logic             zero,
  output logic             pend,
  output logic             tc_wait
);
  localparam logic [PRE_HI_LOG2-1:0] LIM_LO = PRE_HI_LOG2'((1 << PRE_LO_LOG2) - 1);
  localparam logic [PRE_HI_LOG2-1:0] LIM_HI = '1;

  ctl_t                   ctl_q, ctl_n;
  logic [BUS_W-1:0]       tc_q, tc_n, cnt_q, cnt_n;
  logic [PRE_HI_LOG2-1:0] pre_q, pre_n, lim;
  logic                   run_q, run_n, arm_q, arm_n, tcp_q, tcp_n;
  logic                   zero_q, zero_n, pend_q, pend_n, trig_q;
  logic                   edge_hit, tick;

  always_comb begin
    ctl_n  = ctl_q;
    tc_n   = tc_q;
    cnt_n  = cnt_q;
    pre_n  = pre_q;
    run_n  = run_q;
    arm_n  = arm_q;
    tcp_n  = tcp_q;
    zero_n = 1'b0;
    pend_n = pend_q;
    edge_hit = ctl_q.rise ? (trig & ~trig_q) : (~trig & trig_q);
    lim    = ctl_q.div_hi ? LIM_HI : LIM_LO;
    tick   = run_q && (ctl_q.cnt_mode ? edge_hit : (pre_q == lim));

    if (run_q && !ctl_q.cnt_mode)
      pre_n = (pre_q == lim) ? '0 : pre_q + 1'b1;
    if (arm_q && edge_hit) begin
      arm_n = 1'b0;
      run_n = 1'b1;
      pre_n = '0;
    end
    if (clr_pend) pend_n = 1'b0;
    if (tick) begin
      if (cnt_q == BUS_W'(1)) begin
        cnt_n  = tc_q;
        zero_n = 1'b1;
        if (ctl_q.ie) pend_n = 1'b1;
      end else begin
        cnt_n = cnt_q - 1'b1;
      end
    end

    if (wr) begin
      if (tcp_q) begin
        tc_n  = wdata;
        tcp_n = 1'b0;
        if (!run_q) begin
          cnt_n = wdata;
          pre_n = '0;
          if (ctl_q.cnt_mode || !ctl_q.trig_start) run_n = 1'b1;
          else                                     arm_n = 1'b1;
        end
      end else if (wdata[0]) begin
        ctl_n = ctl_t'(wdata);
        if (wdata[2]) tcp_n = 1'b1;
        if (wdata[1]) begin
          run_n = 1'b0;
          arm_n = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q  <= '0;
      tc_q   <= '0;
      cnt_q  <= '0;
      pre_q  <= '0;
      run_q  <= 1'b0;
      arm_q  <= 1'b0;
      tcp_q  <= 1'b0;
      zero_q <= 1'b0;
      pend_q <= 1'b0;
      trig_q <= 1'b0;
    end else begin
      ctl_q  <= ctl_n;
      tc_q   <= tc_n;
      cnt_q  <= cnt_n;
      pre_q  <= pre_n;
      run_q  <= run_n;
      arm_q  <= arm_n;
      tcp_q  <= tcp_n;
      zero_q <= zero_n;
      pend_q <= pend_n;
      trig_q <= trig;
    end
  end

  assign cnt     = cnt_q;
  assign zero    = zero_q;
  assign pend    = pend_q;
  assign tc_wait = tcp_q;
endmodule

// File: rtl/qt_prio.sv
module qt_prio #(
  parameter int NUM_CH = 4,
  localparam int ID_W = $clog2(NUM_CH)
) (
  input  logic [NUM_CH-1:0] pend,
  output logic              any,
  output logic [ID_W-1:0]   id
);
  always_comb begin
    any = |pend;
    id  = '0;
    for (int i = NUM_CH - 1; i >= 0; i--)
      if (pend[i]) id = ID_W'(i);
  end
endmodule

// File: rtl/quad_timer.sv
module quad_timer
  import qt_pkg::*;
#(
  parameter int NUM_CH      = 4,
  parameter int PRE_LO_LOG2 = 4,
  parameter int PRE_HI_LOG2 = 8,
  localparam int ID_W   = $clog2(NUM_CH),
  localparam int NUM_ZC = NUM_CH - 1,
  localparam int BASE_W = BUS_W - ID_W - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ID_W-1:0]   sel,
  input  logic              wr_en,
  input  logic [BUS_W-1:0]  wr_data,
  output logic [BUS_W-1:0]  rd_data,
  input  logic [NUM_CH-1:0] trig,
  output logic [NUM_ZC-1:0] zc,
  output logic              irq,
  output logic [BUS_W-1:0]  irq_vec,
  input  logic              irq_ack
);
  logic [BUS_W-1:0]  cnt_a [NUM_CH];
  logic [NUM_CH-1:0] zero_w, pend_w, tcw_w, clr_w;
  logic [ID_W-1:0]   id_w;
  logic              any_w, base_we;
  logic [BASE_W-1:0] base_q, base_n;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    assign clr_w[g] = irq_ack && any_w && (id_w == ID_W'(g));
    qt_channel #(
      .PRE_LO_LOG2(PRE_LO_LOG2),
      .PRE_HI_LOG2(PRE_HI_LOG2)
    ) u_ch (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr      (wr_en && (sel == ID_W'(g))),
      .wdata   (wr_data),
      .trig    (trig[g]),
      .clr_pend(clr_w[g]),
      .cnt     (cnt_a[g]),
      .zero    (zero_w[g]),
      .pend    (pend_w[g]),
      .tc_wait (tcw_w[g])
    );
  end

  qt_prio #(.NUM_CH(NUM_CH)) u_prio (
    .pend(pend_w),
    .any (any_w),
    .id  (id_w)
  );

  always_comb begin
    base_we = wr_en && !wr_data[0] && !tcw_w[sel];
    base_n  = base_we ? wr_data[BUS_W-1 -: BASE_W] : base_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) base_q <= '0;
    else        base_q <= base_n;
  end

  assign rd_data = cnt_a[sel];
  assign zc      = zero_w[NUM_ZC-1:0];
  assign irq     = any_w;
  assign irq_vec = {base_q, id_w, 1'b0};
endmodule

// File: rtl/quad_timer_chk.sv
module quad_timer_chk #(
  parameter int NUM_CH = 4,
  localparam int NUM_ZC = NUM_CH - 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              irq,
  input logic              irq_ack,
  input logic [7:0]        irq_vec,
  input logic [NUM_ZC-1:0] zc,
  input logic [NUM_CH-1:0] pend
);
  for (genvar g = 0; g < NUM_ZC; g++) begin : g_zc
    // R5: zero-count pulse lasts one clock
    a_r5_zc_single: assert property (@(posedge clk) disable iff (!rst_n)
      zc[g] |=> !zc[g]);
  end

  // R1: vector base moves only after a write
  a_r1_base_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_en) |-> $stable(irq_vec[7:3]));

  // R9: presented channel is pending and nothing of higher priority is
  a_r9_top_pending: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (pend[irq_vec[2:1]] &&
             ((pend & ((NUM_CH'(1) << irq_vec[2:1]) - NUM_CH'(1))) == '0)));

  // R10: without acknowledge, the presented channel only moves to higher priority
  a_r10_no_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && $past(irq) && !$past(irq_ack)) |-> (irq_vec[2:1] <= $past(irq_vec[2:1])));

  // R9: irq is low whenever no channel is pending
  a_r9_irq_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (pend == '0) |-> !irq);
endmodule

bind quad_timer quad_timer_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .wr_en  (wr_en),
  .irq    (irq),
  .irq_ack(irq_ack),
  .irq_vec(irq_vec),
  .zc     (zc),
  .pend   (pend_w)
);

// File: tb/quad_timer_test.sv
module quad_timer_test;
  logic       clk, rst_n, wr_en, irq, irq_ack;
  logic [1:0] sel;
  logic [7:0] wr_data, rd_data, irq_vec;
  logic [3:0] trig;
  logic [2:0] zc;
  int checks = 0, errors = 0;
  bit done = 0;

  quad_timer uut (
    .clk(clk), .rst_n(rst_n), .sel(sel), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .trig(trig), .zc(zc), .irq(irq), .irq_vec(irq_vec),
    .irq_ack(irq_ack)
  );

  initial clk = 0;
  always #2 clk = ~clk;

  // {channel, control, time constant, expected period in clocks}
  localparam logic [39:0] VEC [0:3] = '{
    {8'd0, 8'h05, 8'd3, 16'd48},
    {8'd1, 8'h25, 8'd2, 16'd512},
    {8'd2, 8'h05, 8'd0, 16'd4096},
    {8'd0, 8'h05, 8'd1, 16'd16}
  };

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] ch, input logic [7:0] d);
    @(negedge clk);
    sel = ch; wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic period(input int ch, output int n);
    int guard = 0;
    n = 0;
    while (!zc[ch] && guard < 10000) begin @(negedge clk); guard++; end
    do begin @(negedge clk); n++; end while (!zc[ch] && n < 10000);
  endtask

  task automatic tick(input int ch, input logic v);
    @(negedge clk);
    trig[ch] = v;
    @(negedge clk);
  endtask

  initial begin
    int n;
    bit zc_seen;
    rst_n = 0; wr_en = 0; sel = 0; wr_data = 0; trig = 0; irq_ack = 0;
    repeat (3) @(negedge clk);
    check("R11 rd_data", rd_data, 0);
    check("R11 irq", irq, 0);
    check("R11 irq_vec", irq_vec, 0);
    check("R11 zc", zc, 0);
    rst_n = 1;
    @(negedge clk);

    wr(0, 8'hA0);
    check("R1 vector base", irq_vec, 8'hA0);

    // table: timer periods (R3, R4, R5) and load readback (R2)
    foreach (VEC[i]) begin
      sel = VEC[i][33:32];
      wr(VEC[i][33:32], VEC[i][31:24]);
      wr(VEC[i][33:32], VEC[i][23:16]);
      check("R2 count loaded", rd_data, VEC[i][23:16]);
      period(VEC[i][33:32], n);
      check("R3 R4 R5 period", n, VEC[i][15:0]);
      wr(VEC[i][33:32], 8'h03);
    end
    check("R1 base kept over time constants", irq_vec, 8'hA0);

    // counter mode, rising edges (R6)
    wr(1, 8'h55); wr(1, 8'd3);
    tick(1, 1); check("R6 rise count", rd_data, 2);
    tick(1, 0); check("R6 fall ignored", rd_data, 2);
    tick(1, 1); check("R6 rise count", rd_data, 1);
    tick(1, 0);
    @(negedge clk); trig[1] = 1;
    @(negedge clk);
    check("R5 reload", rd_data, 3);
    check("R5 zc pulse ch1", zc[1], 1);
    // falling edge mode
    wr(1, 8'h03); wr(1, 8'h45); wr(1, 8'd2);
    tick(1, 0); check("R6 falling count", rd_data, 1);
    tick(1, 1); check("R6 rise ignored", rd_data, 1);

    // trigger-started timer (R7)
    sel = 2;
    wr(2, 8'h1D); wr(2, 8'd2);
    repeat (40) @(negedge clk);
    check("R7 held before trigger", rd_data, 2);
    @(negedge clk); trig[2] = 1;
    repeat (10) @(negedge clk);
    check("R7 not yet divided", rd_data, 2);
    repeat (10) @(negedge clk);
    check("R7 started by trigger", rd_data, 1);

    // stop (R8)
    wr(2, 8'h03);
    n = rd_data;
    zc_seen = 0;
    repeat (200) begin @(negedge clk); if (zc[2]) zc_seen = 1; end
    check("R8 count holds", rd_data, n);
    check("R8 no pulse", zc_seen, 0);

    // interrupts (R9, R10)
    @(negedge clk); trig = 0;
    @(negedge clk);
    wr(0, 8'h57); wr(0, 8'd1);
    wr(1, 8'hD7); wr(1, 8'd1);
    wr(2, 8'hD7); wr(2, 8'd1);
    wr(3, 8'hD7); wr(3, 8'd1);
    check("R9 idle vector", irq_vec, 8'hA0);
    @(negedge clk); trig[0] = 1;
    @(negedge clk);
    check("R5 zc pulse ch0", zc[0], 1);
    check("R9 disabled channel no irq", irq, 0);
    @(negedge clk); trig[1] = 1; trig[2] = 1;
    @(negedge clk);
    check("R9 irq raised", irq, 1);
    check("R9 channel 1 first", irq_vec, 8'hA2);
    irq_ack = 1; @(negedge clk); irq_ack = 0;
    check("R10 next channel 2", irq_vec, 8'hA4);
    check("R10 irq still set", irq, 1);
    irq_ack = 1; @(negedge clk); irq_ack = 0;
    check("R10 all cleared", irq, 0);
    trig[3] = 1; @(negedge clk);
    check("R9 channel 3 vector", irq_vec, 8'hA6);
    wr(0, 8'h58);
    check("R1 new base", irq_vec, 8'h5E);
    irq_ack = 1; @(negedge clk); irq_ack = 0;
    check("R10 cleared ch3", irq, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule